// File: doc/BRIEF.md
# Bundled Three-Bit Accumulator Processor

This block is a small 16-bit processor with an accumulator. It is meant for control tasks where the program must be as small as possible. Each 16-bit program word carries five 3-bit operations and one flag bit. The core steps through those operations one after another. It holds three 16-bit registers:

- a program counter,
- an address/data register D,
- an accumulator A.

Every memory access goes through one word-addressed synchronous port: bundle fetches, inline constant reads, operand reads and stores. That port has a read latency of one cycle. Constants are not carried in immediate fields. They are read from the word stream at the program counter, which already points past the current bundle while its slots run. So the constants used by a bundle are placed in the words directly after it, in the order they are used.

The core is a four-state machine:

| State | What happens | Next state |
|---|---|---|
| FETCH | Puts the program counter on the address bus. | Always DECODE. |
| DECODE | Captures the returned word and increments the program counter. | Always EXEC. |
| EXEC | Runs the current slot. A swap, a store or a jump completes here. | WAIT for a read that needs returned data. After a completed slot: EXEC for the next slot, or FETCH when the bundle is finished or a jump is taken. |
| WAIT | Applies the returned data. | EXEC for the next slot, or FETCH after the last slot. |

Each completed slot produces a one-cycle trace record. A reference model can compare against it.

Top module: `bundle_cpu`

## Requirements
- R1: While reset is held and after it is released, the program counter, A and D are zero and no retire is reported. The first memory access is a fetch from address 0, with `mem_we` low.
- R2: A bundle word holds slot 1 in bits 15:13, slot 2 in 12:10, slot 3 in 9:7, slot 4 in 6:4, slot 5 in 3:1 and the skip flag in bit 0. Slots run in order from slot 1 to slot 5.
- R3: When bit 0 of the bundle is 1, slot 5 is not executed and produces no retire record. The next bundle is fetched instead.
- R4: Opcode 0 exchanges A and D. Two opcode-0 slots in a row leave A and D unchanged, which makes a no-operation.
- R5: Opcode 1 loads D from memory at the program counter and then increments the program counter. Because the counter already points past the bundle, successive opcode-1 slots read the words that directly follow the bundle, in order.
- R6: Opcode 2 loads A from memory at D. Opcode 3 writes A to memory at D.
- R7: Opcode 4 adds the word at memory[D] to A, modulo 2^16, and keeps no carry.
- R8: Opcode 5 sets A to A AND memory[D]. Opcode 6 sets A to A XOR memory[D].
- R9: Opcode 7 loads the program counter from D when A is zero, and does nothing otherwise. When the jump is taken, the rest of the bundle is dropped and the next bundle is fetched from the new counter value.
- R10: For every executed slot, `ret_valid` is high for exactly one cycle. During that cycle `ret_op` shows the slot's opcode, and `ret_pc`, `ret_a` and `ret_d` show the register values after that slot.
- R11: Slots that touch memory take two cycles: an access cycle and a result cycle. A store drives `mem_we` for one cycle, with address D and data A, and retires in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for the current memory access |
| mem_we | output | 1 | Write enable for a store |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| ret_valid | output | 1 | One-cycle strobe for each retired slot |
| ret_op | output | 3 | Opcode of the retired slot |
| ret_pc | output | 16 | Program counter after the retired slot |
| ret_a | output | 16 | Accumulator after the retired slot |
| ret_d | output | 16 | D register after the retired slot |

## Verification
A wrong slot index, a wrong skip decision or a jump that does not cut the bundle short adds, drops or reorders retire records. Such a fault shows in the trace at the first affected slot, one cycle after that slot completes. An error in the data path shows in the `ret_a`, `ret_d` or `ret_pc` values of the same record. A program counter that is off by one shows as a wrong constant at the next opcode-1 slot, and later as wrong data in the stores checked at the end of the run.

// File: rtl/cpu3_pkg.sv
package cpu3_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SWP = 3'd0,
        OP_LDI = 3'd1,
        OP_LDA = 3'd2,
        OP_STO = 3'd3,
        OP_ADD = 3'd4,
        OP_AND = 3'd5,
        OP_XOR = 3'd6,
        OP_JZ  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_WAIT   = 2'd3
    } state_e;

endpackage

// File: rtl/cpu3_slot_pick.sv
// Selects the opcode of the active slot in a bundle.
// Also flags the last slot that will execute (R2, R3).
module cpu3_slot_pick #(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 5,
    parameter int OP_W   = 3,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [WORD_W-1:0] bundle,
    input  logic [IDX_W-1:0]  idx,
    output logic [OP_W-1:0]   op,
    output logic              last
);
    logic [OP_W-1:0] field [SLOTS];

    // Slot 1 sits in the most significant bits; bit 0 is the skip flag.
    for (genvar i = 0; i < SLOTS; i++) begin : g_field
        assign field[i] = bundle[WORD_W-1-i*OP_W -: OP_W];
    end

    assign op = field[idx];

    always_comb begin
        last = (idx == IDX_W'(SLOTS-1));
        if (bundle[0] && idx == IDX_W'(SLOTS-2)) begin
            last = 1'b1;
        end
    end
endmodule

// File: rtl/cpu3_alu.sv
// Produces the new accumulator value for the memory-operand operations.
module cpu3_alu #(
    parameter int WORD_W = 16
) (
    input  cpu3_pkg::op_e     op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mval,
    output logic [WORD_W-1:0] res
);
    import cpu3_pkg::*;

    always_comb begin
        unique case (op)
            OP_LDA:  res = mval;
            OP_ADD:  res = acc + mval;
            OP_AND:  res = acc & mval;
            OP_XOR:  res = acc ^ mval;
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/bundle_cpu.sv
module bundle_cpu #(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ret_valid,
    output logic [2:0]        ret_op,
    output logic [WORD_W-1:0] ret_pc,
    output logic [WORD_W-1:0] ret_a,
    output logic [WORD_W-1:0] ret_d
);
    import cpu3_pkg::*;

    localparam int IDX_W = $clog2(SLOTS);

    state_e            state, nxt;
    logic [WORD_W-1:0] pc, acc, dreg, ir;
    logic [IDX_W-1:0]  slot;
    logic [OP_W-1:0]   raw_op;
    op_e               cur_op;
    logic              last_slot;
    logic              retire, jump;
    logic [WORD_W-1:0] alu_res;
    logic              rv_q;
    logic [2:0]        rop_q;

    cpu3_slot_pick #(.WORD_W(WORD_W), .SLOTS(SLOTS), .OP_W(OP_W)) u_pick (
        .bundle (ir),
        .idx    (slot),
        .op     (raw_op),
        .last   (last_slot)
    );

    assign cur_op = op_e'(raw_op);

    cpu3_alu #(.WORD_W(WORD_W)) u_alu (
        .op   (cur_op),
        .acc  (acc),
        .mval (mem_rdata),
        .res  (alu_res)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

    // Outputs and next-state decode
    always_comb begin
        nxt       = state;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = acc;
        retire    = 1'b0;
        jump      = 1'b0;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = ST_EXEC;
            ST_EXEC: begin
                unique case (cur_op)
                    OP_SWP: begin
                        retire = 1'b1;
                        nxt    = last_slot ? ST_FETCH : ST_EXEC;
                    end
                    OP_LDI: begin
                        mem_addr = pc;
                        nxt      = ST_WAIT;
                    end
                    OP_STO: begin
                        mem_addr = dreg;
                        mem_we   = 1'b1;
                        retire   = 1'b1;
                        nxt      = last_slot ? ST_FETCH : ST_EXEC;
                    end
                    OP_JZ: begin
                        retire = 1'b1;
                        if (acc == '0) begin
                            jump = 1'b1;
                            nxt  = ST_FETCH;
                        end else begin
                            nxt  = last_slot ? ST_FETCH : ST_EXEC;
                        end
                    end
                    default: begin
                        mem_addr = dreg;
                        nxt      = ST_WAIT;
                    end
                endcase
            end
            ST_WAIT: begin
                retire = 1'b1;
                nxt    = last_slot ? ST_FETCH : ST_EXEC;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            acc   <= '0;
            dreg  <= '0;
            ir    <= '0;
            slot  <= '0;
            rv_q  <= 1'b0;
            rop_q <= '0;
        end else begin
            rv_q  <= retire;
            rop_q <= raw_op;
            if (state == ST_DECODE) begin
                ir   <= mem_rdata;
                pc   <= pc + 1'b1;
                slot <= '0;
            end
            if (state == ST_EXEC) begin
                if (cur_op == OP_SWP) begin
                    acc  <= dreg;
                    dreg <= acc;
                end
                if (jump) pc <= dreg;
            end
            if (state == ST_WAIT) begin
                if (cur_op == OP_LDI) begin
                    dreg <= mem_rdata;
                    pc   <= pc + 1'b1;
                end else begin
                    acc  <= alu_res;
                end
            end
            if (retire && !last_slot && !jump) slot <= slot + 1'b1;
        end
    end

    assign ret_valid = rv_q;
    assign ret_op    = rop_q;
    assign ret_pc    = pc;
    assign ret_a     = acc;
    assign ret_d     = dreg;
endmodule

// File: rtl/bundle_cpu_chk.sv
module bundle_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic [15:0] mem_rdata,
    input logic        ret_valid,
    input logic [2:0]  ret_op,
    input logic [15:0] ret_pc,
    input logic [15:0] ret_a,
    input logic [15:0] ret_d
);
    // R4
    swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == 3'd0) |-> (ret_a == $past(ret_d) && ret_d == $past(ret_a)));

    // R5
    const_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == 3'd1) |-> (ret_pc == $past(ret_pc) + 16'd1 && ret_d == $past(mem_rdata)));

    // R6
    load_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == 3'd2) |-> (ret_a == $past(mem_rdata)));

    // R7
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == 3'd4) |-> (ret_a == 16'($past(ret_a) + $past(mem_rdata))));

    // R9
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_op == 3'd7 && $past(ret_a) == 16'd0) |-> (ret_pc == $past(ret_d)));

    // R11
    store_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ret_valid && ret_op == 3'd3));
endmodule

bind bundle_cpu bundle_cpu_chk chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .ret_valid (ret_valid),
    .ret_op    (ret_op),
    .ret_pc    (ret_pc),
    .ret_a     (ret_a),
    .ret_d     (ret_d)
);

// File: tb/bundle_cpu_test.sv
module bundle_cpu_test;
    localparam int K = 30;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] pc;
        logic [15:0] a;
        logic [15:0] d;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic        ret_valid;
    logic [2:0]  ret_op;
    logic [15:0] ret_pc, ret_a, ret_d;

    int compared = 0;
    int mismatched = 0;
    int seen = 0;
    item_t exp_q[$];

    logic [15:0] mem     [0:1023];
    logic [15:0] ref_mem [0:1023];

    always #10 clk = ~clk;

    bundle_cpu uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ret_valid(ret_valid),
        .ret_op(ret_op), .ret_pc(ret_pc), .ret_a(ret_a), .ret_d(ret_d)
    );

    // Synchronous memory with one cycle of read latency (R11)
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    function automatic logic [15:0] bnd(input int o1, o2, o3, o4, o5, input bit n);
        return {3'(o1), 3'(o2), 3'(o3), 3'(o4), 3'(o5), n};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2, 3'd3: return "R6";
            3'd4: return "R7";
            3'd5, 3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Driver: reference model, fed the R2 layout, pushes expected retire records
    task automatic drive_expected();
        logic [15:0] pc = 0, a = 0, d = 0, ir;
        int n = 0;
        while (n < K) begin
            ir = ref_mem[pc[9:0]];
            pc = pc + 1;
            for (int s = 0; s < 5 && n < K; s++) begin
                logic [2:0] op;
                bit jmp = 0;
                if (s == 4 && ir[0]) break;            // R3
                op = ir[15-3*s -: 3];
                case (op)
                    3'd0: begin logic [15:0] t = a; a = d; d = t; end
                    3'd1: begin d = ref_mem[pc[9:0]]; pc = pc + 1; end
                    3'd2: a = ref_mem[d[9:0]];
                    3'd3: ref_mem[d[9:0]] = a;
                    3'd4: a = a + ref_mem[d[9:0]];
                    3'd5: a = a & ref_mem[d[9:0]];
                    3'd6: a = a ^ ref_mem[d[9:0]];
                    default: if (a == 0) begin pc = d; jmp = 1; end
                endcase
                exp_q.push_back('{op, pc, a, d});
                n++;
                if (jmp) break;
            end
        end
    endtask

    // Monitor: compares each retire record against the queue (R10)
    always @(negedge clk) begin
        if (rst_n && ret_valid && seen < K) begin
            item_t e;
            string r;
            e = exp_q.pop_front();
            r = req_of(e.op);
            seen++;
            check({r, " op (R2 R3 R10)"}, 16'(ret_op), 16'(e.op));
            check({r, " pc"}, ret_pc, e.pc);
            check({r, " a"},  ret_a,  e.a);
            check({r, " d"},  ret_d,  e.d);
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        mem[0]  = bnd(1, 2, 1, 4, 1, 0);
        mem[1]  = 16'h0100; mem[2] = 16'h0101; mem[3] = 16'h0102;
        mem[4]  = bnd(3, 1, 5, 1, 6, 0);
        mem[5]  = 16'h0103; mem[6] = 16'h0104;
        mem[7]  = bnd(1, 7, 0, 0, 0, 1);
        mem[8]  = 16'h0020;
        mem[9]  = bnd(1, 2, 1, 7, 3, 0);
        mem[10] = 16'h0105; mem[11] = 16'h0020;
        mem[32] = bnd(1, 2, 1, 3, 6, 1);
        mem[33] = 16'h0106; mem[34] = 16'h0107;
        mem[256] = 16'hFFF0; mem[257] = 16'h0025;
        mem[259] = 16'h00FF; mem[260] = 16'h0F0F;
        mem[261] = 16'h0000; mem[262] = 16'hBEEF;
        for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
        drive_expected();

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ret_valid", 16'(ret_valid), 16'd0);
        check("R1 pc", ret_pc, 16'd0);
        check("R1 a", ret_a, 16'd0);
        check("R1 d", ret_d, 16'd0);
        check("R1 fetch addr", mem_addr, 16'd0);
        check("R1 we", 16'(mem_we), 16'd0);
        rst_n = 1'b1;

        fork
            begin : wait_done
                wait (seen == K);
            end
            begin : watchdog
                repeat (5000) @(posedge clk);
                compared++;
                mismatched++;
                $display("FAIL R10 watchdog: actual %0d retires expected %0d", seen, K);
            end
        join_any
        disable fork;
        repeat (4) @(negedge clk);
        // R7 wraps the sum; R6/R11 store it to memory
        check("R7 R11 stored sum", mem[258], 16'h0015);
        check("R6 stored after jump (R9)", mem[263], 16'hBEEF);
        check("R9 code word untouched", mem[32], bnd(1, 2, 1, 3, 6, 1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule